// File: doc/BRIEF.md
# Exception Return and Link-Flag Controller

This block sits beside the privileged-state logic of a small in-order CPU. It watches each issued instruction word, recognises the two exception-return forms, and carries out the return. The plain form and the "keep link" form return in exactly the same way. The only difference is that the plain form also drops the load-linked/store-conditional reservation, and the "keep link" form leaves it in place. A return goes back through the error level when the incoming ERL bit is set, and through the exception level otherwise. The block reports the new PC, a one-cycle redirect strobe and the rewritten level bits, which are written into the status register held elsewhere.

The same block owns the link flag. A load-linked event arms the flag and records the address. A store-conditional event consumes the flag and reports pass or fail. A return in a forbidden slot under release-6 rules raises a reserved-instruction strobe instead of executing. So does the "keep link" form on a configuration built without it. A read-only configuration word advertises whether the "keep link" form exists.

Instructions arrive on a valid-qualified input with no ready signal. The block accepts a word in every cycle and never applies back-pressure. Every result appears on registered outputs in the cycle after the input is sampled. A strobe lasts one cycle for each input it answers.

Top module: `eret_llsc_ctrl`

## Requirements
- R1: In 32-bit mode (`compact_i`=0), only the exact word 0x42000018 is the plain return and only 0x42000058 is the keep-link return. Opcode bit 6 is what separates the two. Any other word, including one that differs in a single bit, does nothing.
- R2: In compressed mode (`compact_i`=1), only 0x0000F37C is the plain return and only 0x0001F37C is the keep-link return, with bit 16 as the selector. The 32-bit-mode words do nothing in this mode.
- R3: An executed plain return leaves `llbit_o` at 0 one cycle later, unless a load-linked arrives in the same cycle. A store-conditional to the linked address then fails.
- R4: An executed keep-link return leaves `llbit_o` unchanged. A following store-conditional to the linked address still succeeds.
- R5: An executed return pulses `redirect_o` and `status_we_o` for one cycle, one cycle after the input. When `status_erl_i`=1, `pc_o` takes `errorepc_i`, `status_erl_o`=0 and `status_exl_o` repeats `status_exl_i`. When `status_erl_i`=0, `pc_o` takes `epc_i` and both level outputs are 0. `pc_o` and the level outputs hold their values between returns.
- R6: A return with `r6_mode_i`=1 and `delay_slot_i`=1 pulses `ri_o` instead. It does not redirect, does not write status and does not change the link flag. If only one of the two inputs is set, the return executes.
- R7: When `SUPPORT_NC`=0, the keep-link word pulses `ri_o` and is not executed. The plain word still executes.
- R8: `config5_o` has bit 4 equal to `SUPPORT_NC`, and every other bit is 0.
- R9: A store-conditional pulses `sc_done_o` one cycle later. `sc_ok_o`=1 only if the flag was set and the store address equals the linked address in all bits above the low `GRAN` bits. The flag is 0 afterwards.
- R10: A store-conditional in the same cycle as another event is judged on the flag as it stood before that cycle. A load-linked in the same cycle as a store-conditional or plain return wins, so the flag ends at 1.
- R11: While reset is held, all strobes, `llbit_o`, `pc_o` and the level outputs are 0.
- R12: A return word with `instr_valid_i`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| compact_i | input | 1 | Compressed instruction mode |
| delay_slot_i | input | 1 | Instruction sits in a delay or forbidden slot |
| r6_mode_i | input | 1 | Release-6 rules active |
| status_erl_i | input | 1 | Current error-level bit |
| status_exl_i | input | 1 | Current exception-level bit |
| epc_i | input | XLEN (32) | Exception return address |
| errorepc_i | input | XLEN (32) | Error return address |
| ll_i | input | 1 | Load-linked event |
| ll_addr_i | input | ADDR_W (32) | Load-linked address |
| sc_i | input | 1 | Store-conditional event |
| sc_addr_i | input | ADDR_W (32) | Store-conditional address |
| redirect_o | output | 1 | PC redirect strobe |
| pc_o | output | XLEN (32) | Return target |
| status_we_o | output | 1 | Level bits write strobe |
| status_erl_o | output | 1 | New error-level bit |
| status_exl_o | output | 1 | New exception-level bit |
| ri_o | output | 1 | Reserved-instruction exception strobe |
| llbit_o | output | 1 | Link flag |
| sc_done_o | output | 1 | Store-conditional result valid |
| sc_ok_o | output | 1 | Store-conditional succeeded |
| config5_o | output | 32 | Configuration word, capability at bit 4 |

## Verification
The bench builds two copies of the block side by side on the same stimulus. One has `SUPPORT_NC`=1 and the other `SUPPORT_NC`=0, so the keep-link word is seen both as a working return and as a reserved instruction, and both values of the capability bit are observed. Both copies use `GRAN`=2. This makes store-conditional addresses that differ only in the low two bits count as a match, while a difference one bit higher counts as a miss. Same-cycle mixes of load-linked, store-conditional and returns check the ordering rule directly.

// File: rtl/eret_pkg.sv
package eret_pkg;
  typedef enum logic [1:0] {
    RET_NONE    = 2'd0,
    RET_PLAIN   = 2'd1,
    RET_KEEP    = 2'd2
  } ret_kind_e;

  // 32-bit mode encodings: bit 6 picks the keep-link form
  localparam int unsigned STD_SEL_BIT = 6;
  localparam logic [31:0] STD_PLAIN   = 32'h4200_0018;
  localparam logic [31:0] STD_KEEP    = STD_PLAIN | (32'h1 << STD_SEL_BIT);

  // compressed mode encodings: bit 16 picks the keep-link form
  localparam int unsigned CMP_SEL_BIT = 16;
  localparam logic [31:0] CMP_PLAIN   = 32'h0000_F37C;
  localparam logic [31:0] CMP_KEEP    = CMP_PLAIN | (32'h1 << CMP_SEL_BIT);

  localparam int unsigned CAP_BIT     = 4;
endpackage

// File: rtl/eret_decode.sv
module eret_decode
  import eret_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] word_i,
  input  logic        compact_i,
  output ret_kind_e   kind_o
);
  logic [31:0] plain_w;
  logic [31:0] keep_w;

  always_comb begin
    plain_w = compact_i ? CMP_PLAIN : STD_PLAIN;
    keep_w  = compact_i ? CMP_KEEP  : STD_KEEP;
    kind_o  = RET_NONE;
    if (valid_i) begin
      if (word_i == plain_w)     kind_o = RET_PLAIN;
      else if (word_i == keep_w) kind_o = RET_KEEP;
    end
  end
endmodule

// File: rtl/eret_return_unit.sv
module eret_return_unit
  import eret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SUPPORT_NC = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ret_kind_e       kind_i,
  input  logic            r6_mode_i,
  input  logic            delay_slot_i,
  input  logic            status_erl_i,
  input  logic            status_exl_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] errorepc_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] pc_o,
  output logic            status_we_o,
  output logic            status_erl_o,
  output logic            status_exl_o,
  output logic            ri_o,
  output logic            clear_link_o
);
  logic keep_allowed;
  logic is_ret;
  logic fault;
  logic exec;

  generate
    if (SUPPORT_NC) begin : g_keep_on
      assign keep_allowed = 1'b1;
    end else begin : g_keep_off
      assign keep_allowed = 1'b0;
    end
  endgenerate

  always_comb begin
    is_ret       = (kind_i != RET_NONE);
    fault        = is_ret && ((r6_mode_i && delay_slot_i) ||
                              (kind_i == RET_KEEP && !keep_allowed));
    exec         = is_ret && !fault;
    clear_link_o = exec && (kind_i == RET_PLAIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o   <= 1'b0;
      status_we_o  <= 1'b0;
      ri_o         <= 1'b0;
      pc_o         <= '0;
      status_erl_o <= 1'b0;
      status_exl_o <= 1'b0;
    end else begin
      redirect_o  <= exec;
      status_we_o <= exec;
      ri_o        <= fault;
      if (exec) begin
        if (status_erl_i) begin
          pc_o         <= errorepc_i;
          status_erl_o <= 1'b0;
          status_exl_o <= status_exl_i;
        end else begin
          pc_o         <= epc_i;
          status_erl_o <= 1'b0;
          status_exl_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eret_link_tracker.sv
module eret_link_tracker #(
  parameter int ADDR_W = 32,
  parameter int GRAN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              sc_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic              clear_i,
  output logic              link_o,
  output logic              sc_done_o,
  output logic              sc_ok_o
);
  localparam logic [ADDR_W-1:0] CMP_MASK = {ADDR_W{1'b1}} << GRAN;

  logic [ADDR_W-1:0] linked_q;
  logic              hit;

  always_comb hit = ((linked_q ^ sc_addr_i) & CMP_MASK) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_o    <= 1'b0;
      linked_q  <= '0;
      sc_done_o <= 1'b0;
      sc_ok_o   <= 1'b0;
    end else begin
      sc_done_o <= sc_i;
      sc_ok_o   <= sc_i && link_o && hit;
      if (ll_i) begin
        link_o   <= 1'b1;
        linked_q <= ll_addr_i;
      end else if (sc_i || clear_i) begin
        link_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eret_llsc_ctrl.sv
module eret_llsc_ctrl
  import eret_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ADDR_W     = 32,
  parameter int GRAN       = 2,
  parameter bit SUPPORT_NC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid_i,
  input  logic [31:0]       instr_i,
  input  logic              compact_i,
  input  logic              delay_slot_i,
  input  logic              r6_mode_i,
  input  logic              status_erl_i,
  input  logic              status_exl_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   errorepc_i,
  input  logic              ll_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              sc_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              status_we_o,
  output logic              status_erl_o,
  output logic              status_exl_o,
  output logic              ri_o,
  output logic              llbit_o,
  output logic              sc_done_o,
  output logic              sc_ok_o,
  output logic [31:0]       config5_o
);
  ret_kind_e kind;
  logic      clear_link;

  always_comb begin
    config5_o          = '0;
    config5_o[CAP_BIT] = SUPPORT_NC;
  end

  eret_decode u_decode (
    .valid_i   (instr_valid_i),
    .word_i    (instr_i),
    .compact_i (compact_i),
    .kind_o    (kind)
  );

  eret_return_unit #(
    .XLEN       (XLEN),
    .SUPPORT_NC (SUPPORT_NC)
  ) u_ret (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind_i       (kind),
    .r6_mode_i    (r6_mode_i),
    .delay_slot_i (delay_slot_i),
    .status_erl_i (status_erl_i),
    .status_exl_i (status_exl_i),
    .epc_i        (epc_i),
    .errorepc_i   (errorepc_i),
    .redirect_o   (redirect_o),
    .pc_o         (pc_o),
    .status_we_o  (status_we_o),
    .status_erl_o (status_erl_o),
    .status_exl_o (status_exl_o),
    .ri_o         (ri_o),
    .clear_link_o (clear_link)
  );

  eret_link_tracker #(
    .ADDR_W (ADDR_W),
    .GRAN   (GRAN)
  ) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .ll_i      (ll_i),
    .ll_addr_i (ll_addr_i),
    .sc_i      (sc_i),
    .sc_addr_i (sc_addr_i),
    .clear_i   (clear_link),
    .link_o    (llbit_o),
    .sc_done_o (sc_done_o),
    .sc_ok_o   (sc_ok_o)
  );
endmodule

// File: rtl/eret_llsc_checker.sv
module eret_llsc_checker #(
  parameter int XLEN       = 32,
  parameter bit SUPPORT_NC = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid_i,
  input logic [31:0]     instr_i,
  input logic            compact_i,
  input logic            delay_slot_i,
  input logic            r6_mode_i,
  input logic            status_erl_i,
  input logic [XLEN-1:0] errorepc_i,
  input logic            ll_i,
  input logic            sc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] pc_o,
  input logic            status_we_o,
  input logic            ri_o,
  input logic            llbit_o,
  input logic            sc_done_o,
  input logic            sc_ok_o
);
  logic std_plain, std_keep, slot_bad;
  assign std_plain = instr_valid_i && !compact_i && instr_i == 32'h4200_0018;
  assign std_keep  = instr_valid_i && !compact_i && instr_i == 32'h4200_0058;
  assign slot_bad  = r6_mode_i && delay_slot_i;

  assert_no_redirect_with_ri_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && ri_o));

  assert_plain_drops_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (std_plain && !slot_bad && !ll_i) |=> !llbit_o);

  assert_keep_holds_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SUPPORT_NC && std_keep && !slot_bad && !ll_i && !sc_i) |=> (llbit_o == $past(llbit_o)));

  assert_error_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (std_plain && status_erl_i && !slot_bad) |=> (redirect_o && pc_o == $past(errorepc_i)));

  assert_slot_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((std_plain || std_keep) && slot_bad) |=> (ri_o && !status_we_o));

  assert_sc_unlinked_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_i && !llbit_o) |=> (sc_done_o && !sc_ok_o));

  assert_ll_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ll_i |=> llbit_o);
endmodule

bind eret_llsc_ctrl eret_llsc_checker #(
  .XLEN       (XLEN),
  .SUPPORT_NC (SUPPORT_NC)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .compact_i     (compact_i),
  .delay_slot_i  (delay_slot_i),
  .r6_mode_i     (r6_mode_i),
  .status_erl_i  (status_erl_i),
  .errorepc_i    (errorepc_i),
  .ll_i          (ll_i),
  .sc_i          (sc_i),
  .redirect_o    (redirect_o),
  .pc_o          (pc_o),
  .status_we_o   (status_we_o),
  .ri_o          (ri_o),
  .llbit_o       (llbit_o),
  .sc_done_o     (sc_done_o),
  .sc_ok_o       (sc_ok_o)
);

// File: tb/test_eret_llsc_ctrl.sv
module test_eret_llsc_ctrl;
  localparam logic [31:0] W_SP = 32'h4200_0018;
  localparam logic [31:0] W_SK = 32'h4200_0058;
  localparam logic [31:0] W_CP = 32'h0000_F37C;
  localparam logic [31:0] W_CK = 32'h0001_F37C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        v, cmp, ds, r6, erl, exl, ll, sc;
  logic [31:0] ins, epc, eepc, lla, sca;

  logic        o_red[2], o_we[2], o_erl[2], o_exl[2], o_ri[2], o_lk[2], o_scd[2], o_sco[2];
  logic [31:0] o_pc[2], o_cfg[2];

  eret_llsc_ctrl #(.SUPPORT_NC(1'b1)) i_eret_llsc_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(v), .instr_i(ins), .compact_i(cmp),
    .delay_slot_i(ds), .r6_mode_i(r6), .status_erl_i(erl), .status_exl_i(exl),
    .epc_i(epc), .errorepc_i(eepc), .ll_i(ll), .ll_addr_i(lla), .sc_i(sc), .sc_addr_i(sca),
    .redirect_o(o_red[0]), .pc_o(o_pc[0]), .status_we_o(o_we[0]), .status_erl_o(o_erl[0]),
    .status_exl_o(o_exl[0]), .ri_o(o_ri[0]), .llbit_o(o_lk[0]), .sc_done_o(o_scd[0]),
    .sc_ok_o(o_sco[0]), .config5_o(o_cfg[0]));

  eret_llsc_ctrl #(.SUPPORT_NC(1'b0)) i_eret_llsc_ctrl_nokeep (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(v), .instr_i(ins), .compact_i(cmp),
    .delay_slot_i(ds), .r6_mode_i(r6), .status_erl_i(erl), .status_exl_i(exl),
    .epc_i(epc), .errorepc_i(eepc), .ll_i(ll), .ll_addr_i(lla), .sc_i(sc), .sc_addr_i(sca),
    .redirect_o(o_red[1]), .pc_o(o_pc[1]), .status_we_o(o_we[1]), .status_erl_o(o_erl[1]),
    .status_exl_o(o_exl[1]), .ri_o(o_ri[1]), .llbit_o(o_lk[1]), .sc_done_o(o_scd[1]),
    .sc_ok_o(o_sco[1]), .config5_o(o_cfg[1]));

  int checks = 0;
  int fails  = 0;

  // behavioural reference state and expectations
  bit          m_link[2];
  logic [31:0] m_addr[2];
  bit          e_red[2], e_we[2], e_erl[2], e_exl[2], e_ri[2], e_lk[2], e_scd[2], e_sco[2];
  logic [31:0] e_pc[2];

  task automatic chk(input string req, input string what, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h t=%0t", req, what, k, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 2; k++) begin
      chk("R5", "redirect", k, 32'(o_red[k]), 32'(e_red[k]));
      chk("R5", "pc", k, o_pc[k], e_pc[k]);
      chk("R5", "status_we", k, 32'(o_we[k]), 32'(e_we[k]));
      chk("R5", "erl", k, 32'(o_erl[k]), 32'(e_erl[k]));
      chk("R5", "exl", k, 32'(o_exl[k]), 32'(e_exl[k]));
      chk("R6", "ri", k, 32'(o_ri[k]), 32'(e_ri[k]));
      chk("R3", "llbit", k, 32'(o_lk[k]), 32'(e_lk[k]));
      chk("R9", "sc_done", k, 32'(o_scd[k]), 32'(e_scd[k]));
      chk("R9", "sc_ok", k, 32'(o_sco[k]), 32'(e_sco[k]));
      chk("R8", "config5", k, o_cfg[k], (k == 0) ? 32'h10 : 32'h0);
    end
  endtask

  task automatic model_edge();
    for (int k = 0; k < 2; k++) begin
      bit has_keep, is_ret, keep, fault, exec, hit;
      has_keep = (k == 0);
      is_ret = v && (cmp ? (ins == W_CP || ins == W_CK) : (ins == W_SP || ins == W_SK));
      keep   = cmp ? (ins == W_CK) : (ins == W_SK);
      fault  = is_ret && ((r6 && ds) || (keep && !has_keep));
      exec   = is_ret && !fault;
      hit    = (m_addr[k] >> 2) == (sca >> 2);
      e_red[k] = exec;
      e_we[k]  = exec;
      e_ri[k]  = fault;
      if (exec) begin
        e_pc[k]  = erl ? eepc : epc;
        e_erl[k] = 1'b0;
        e_exl[k] = erl ? exl : 1'b0;
      end
      e_scd[k] = sc;
      e_sco[k] = sc && m_link[k] && hit;
      if (ll) begin
        m_link[k] = 1'b1;
        m_addr[k] = lla;
      end else if (sc || (exec && !keep)) begin
        m_link[k] = 1'b0;
      end
      e_lk[k] = m_link[k];
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    v = 0; ll = 0; sc = 0; ds = 0; r6 = 0; cmp = 0;
  endtask

  task automatic ret(input logic [31:0] w, input bit c, input bit e);
    v = 1; ins = w; cmp = c; erl = e;
    epc = 32'h8000_1000 + $urandom_range(0, 255) * 4;
    eepc = 32'hBFC0_0000 + $urandom_range(0, 255) * 4;
    exl = $urandom_range(0, 1);
  endtask

  task automatic do_ll(input logic [31:0] a); ll = 1; lla = a; endtask
  task automatic do_sc(input logic [31:0] a); sc = 1; sca = a; endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    v = 0; ins = 0; cmp = 0; ds = 0; r6 = 0; erl = 0; exl = 0;
    epc = 0; eepc = 0; ll = 0; lla = 0; sc = 0; sca = 0;
    for (int k = 0; k < 2; k++) begin
      m_link[k] = 0; m_addr[k] = 0; e_red[k] = 0; e_we[k] = 0; e_erl[k] = 0;
      e_exl[k] = 0; e_ri[k] = 0; e_lk[k] = 0; e_scd[k] = 0; e_sco[k] = 0; e_pc[k] = 0;
    end
    repeat (3) @(negedge clk);
    compare_all();                               // R11 reset state
    rst_n = 1;
    @(negedge clk);

    // R4: LL, keep-link return, SC succeeds (inst0); ri on inst1 (R7)
    do_ll(32'h0000_2000); tick();
    ret(W_SK, 0, 0); tick();
    do_sc(32'h0000_2000); tick();
    // R3: LL, plain return, SC fails
    do_ll(32'h0000_3000); tick();
    ret(W_SP, 0, 0); tick();
    do_sc(32'h0000_3000); tick();
    // R5 error path and exception path
    ret(W_SP, 0, 1); tick();
    ret(W_SK, 0, 1); tick();
    ret(W_SP, 0, 0); tick();
    // R2 compressed forms, and 32-bit words in compressed mode do nothing
    do_ll(32'h40); tick();
    ret(W_CK, 1, 0); tick();
    ret(W_SK, 1, 0); tick();
    ret(W_SP, 1, 1); tick();
    ret(W_CP, 0, 0); tick();
    ret(W_CP, 1, 1); tick();
    // R1 near-miss words
    do_ll(32'h80); tick();
    ret(32'h4200_0019, 0, 0); tick();
    ret(32'h4200_0059, 0, 0); tick();
    ret(32'hC200_0018, 0, 0); tick();
    // R12 valid low
    ret(W_SP, 0, 1); v = 0; tick();
    // R6 slot fault and partial conditions
    ret(W_SP, 0, 0); r6 = 1; ds = 1; tick();
    ret(W_SP, 0, 0); r6 = 1; tick();
    do_ll(32'h100); tick();
    ret(W_SK, 0, 1); ds = 1; tick();
    // R9 granularity and mismatch
    do_ll(32'h0000_1000); tick();
    do_sc(32'h0000_1003); tick();
    do_ll(32'h0000_1000); tick();
    do_sc(32'h0000_1004); tick();
    do_sc(32'h0000_1000); tick();
    // R10 same-cycle mixes
    do_ll(32'h200); tick();
    do_ll(32'h300); do_sc(32'h200); tick();
    do_sc(32'h300); ret(W_SK, 0, 0); tick();
    do_ll(32'h400); ret(W_SP, 0, 0); tick();
    do_sc(32'h400); tick();
    // back-to-back returns
    ret(W_SP, 0, 1); tick();
    ret(W_SP, 0, 0); tick();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: ret(W_SP, 0, 1'($urandom_range(0, 1)));
        1: ret(W_SK, 0, 1'($urandom_range(0, 1)));
        2: ret(W_CP, 1, 1'($urandom_range(0, 1)));
        3: ret(W_CK, 1, 1'($urandom_range(0, 1)));
        4: ret($urandom, 1'($urandom_range(0, 1)), 0);
        default: ;
      endcase
      r6 = 1'($urandom_range(0, 1));
      ds = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) do_ll({26'h0, 3'($urandom_range(0, 3)), 3'($urandom_range(0, 7))});
      if ($urandom_range(0, 2) == 0) do_sc({26'h0, 3'($urandom_range(0, 3)), 3'($urandom_range(0, 7))});
      tick();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule